// File: doc/BRIEF.md
# Banked Scratch Memory Conflict Serializer

This block sits in front of a scratch memory split into 32 banks, each one word of 32 bits wide. It takes one warp request per handshake. A request carries a per-lane enable, a word address and write data for each of up to 32 lanes, plus one flag that marks the whole request as a read or a write. The block breaks the request into the fewest bank passes that contain no conflicts. In each pass every bank is driven in parallel. When the last pass has completed, the block returns the gathered read data together with the number of passes it used.

The bank is the low five bits of the word address, and the remaining bits select the row inside that bank. In every pass, each bank serves the lowest-numbered pending lane that maps to it. Any other pending lane that names the same word is merged into that access. Merging is how a read broadcast happens, and it is also how duplicate writes collapse into a single write. Lanes that hit the same bank at different words wait for a later pass.

A request is presented with `req_valid`. It is taken on a clock edge where `req_ready` is high. `req_ready` then stays low until the result appears. The result is marked by a one-cycle `done` pulse. In that same cycle the block is already able to accept the next request.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A word address maps to bank = address bits [4:0] and row = the upper address bits. A read returns the word last written at that same address.
- R2: A request whose enabled lanes all hit different banks completes in one pass (`pass_cnt` = 1).
- R3: Lanes that hit one bank at different words are served in separate passes. `pass_cnt` equals the largest number of distinct words that any single bank receives within the request.
- R4: Enabled read lanes that name the same word share one bank access, and every one of those lanes receives that word. For example, 32 lanes reading one word take 1 pass.
- R5: When several lanes of one write request name the same word, only the value from the lowest-numbered of those lanes is stored, and they take no extra pass.
- R6: `req_ready` is low from the accepting edge until `done`. `done` is a single-cycle pulse that rises on the (N+1)th rising edge after the accepting edge, where N is the pass count. `req_ready` is high in the `done` cycle.
- R7: `pass_cnt` lies between 1 and 32. A request with no enabled lane reports 1, and 32 lanes on one bank at 32 distinct words report 32.
- R8: In `rd_data`, lane l occupies bits [32l+31:32l]. Disabled lanes, and every lane of a write request, read as zero. `rd_data` holds its value until the next request is accepted.
- R9: After reset, `req_ready` is 1, `done` is 0, `pass_cnt` is 0 and `rd_data` is 0.
- R10: A disabled lane never writes, whatever its address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_lane_en | input | 32 | Per-lane enable, bit l for lane l |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 320 | Word address of lane l at bits [10l+9:10l] |
| req_wdata | input | 1024 | Write data of lane l at bits [32l+31:32l] |
| done | output | 1 | One-cycle completion pulse |
| pass_cnt | output | 6 | Passes used by the last completed request |
| rd_data | output | 1024 | Gathered read data, lane l at bits [32l+31:32l] |

## Verification
Two events can fall in the same cycle: the completion pulse of one request, and the acceptance of the next request. The bench provokes this on every request after the first. It drives the next request in the very cycle where `done` is seen, so that request is taken on the following edge. Each time, the bench judges three things: that the earlier request's read data and pass count were correct in the `done` cycle, that `req_ready` was high in that cycle, and that the newly accepted request finishes with its own correct results and latency.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS  = 2'd1,
    ST_DRAIN = 2'd2
  } bcs_state_e;
endpackage

// File: rtl/bcs_pass_plan.sv
// Chooses, for each bank, the lowest pending lane that maps to it. Every pending
// lane naming that same full word address is merged into the access.
module bcs_pass_plan #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]            pend,
  input  logic [LANES*AW-1:0]         addr,
  input  logic [LANES*DW-1:0]         wdata,
  output logic [BANKS-1:0]            bank_en,
  output logic [BANKS*(AW-$clog2(BANKS))-1:0] bank_row,
  output logic [BANKS*DW-1:0]         bank_wd,
  output logic [LANES-1:0]            serve
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = AW - BW;
  localparam int LW = $clog2(LANES);

  logic [LW-1:0] lead_idx  [BANKS];
  logic [AW-1:0] lead_addr [BANKS];

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_en[b]  = 1'b0;
      lead_idx[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend[l] && (addr[l*AW +: BW] == BW'(b))) begin
          bank_en[b]  = 1'b1;
          lead_idx[b] = LW'(l);
        end
      end
      lead_addr[b]           = addr[lead_idx[b]*AW +: AW];
      bank_row[b*RW +: RW]   = lead_addr[b][AW-1:BW];
      bank_wd[b*DW +: DW]    = wdata[lead_idx[b]*DW +: DW];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      serve[l] = pend[l] && (addr[l*AW +: AW] == lead_addr[addr[l*AW +: BW]]);
    end
  end
endmodule

// File: rtl/bcs_bank.sv
// One bank: synchronous write, registered read with one cycle of latency.
module bcs_bank #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << RW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wd;
      q <= mem[row];
    end
  end
endmodule

// File: rtl/bcs_gather.sv
// Steers each bank's read output to the lanes served by the previous pass.
module bcs_gather #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DW    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clear,
  input  logic                              cap,
  input  logic [LANES-1:0]                  serve,
  input  logic [LANES*$clog2(BANKS)-1:0]    lane_bank,
  input  logic [BANKS*DW-1:0]               bank_q,
  output logic [LANES*DW-1:0]               rd_data
);
  localparam int BW = $clog2(BANKS);

  logic [DW-1:0]       pick [LANES];
  logic [LANES*DW-1:0] rd_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      pick[l] = bank_q[int'(lane_bank[l*BW +: BW])*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rd_q <= '0;
    end else if (cap) begin
      for (int l = 0; l < LANES; l++) begin
        if (serve[l]) rd_q[l*DW +: DW] <= pick[l];
      end
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
  import bcs_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [LANES-1:0]             req_lane_en,
  input  logic                         req_write,
  input  logic [LANES*AW-1:0]          req_addr,
  input  logic [LANES*DW-1:0]          req_wdata,
  output logic                         done,
  output logic [$clog2(LANES+1)-1:0]   pass_cnt,
  output logic [LANES*DW-1:0]          rd_data
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = AW - BW;
  localparam int CW = $clog2(LANES + 1);

  bcs_state_e           state;
  logic [LANES-1:0]     pend;
  logic [LANES-1:0]     pend_act;
  logic [LANES-1:0]     pend_left;
  logic [LANES-1:0]     serve;
  logic [LANES-1:0]     serve_d;
  logic [LANES*AW-1:0]  addr_q;
  logic [LANES*DW-1:0]  wdata_q;
  logic                 write_q;
  logic                 cap_d;
  logic                 done_q;
  logic [CW-1:0]        cnt_q;
  logic [CW-1:0]        pass_q;
  logic                 accept;

  logic [BANKS-1:0]     bank_en;
  logic [BANKS*RW-1:0]  bank_row;
  logic [BANKS*DW-1:0]  bank_wd;
  logic [BANKS*DW-1:0]  bank_q;
  logic [LANES*BW-1:0]  lane_bank;

  assign accept    = req_valid && (state == ST_IDLE);
  assign pend_act  = (state == ST_PASS) ? pend : '0;
  assign pend_left = pend & ~serve;

  bcs_pass_plan #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) u_plan (
    .pend     (pend_act),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .bank_en  (bank_en),
    .bank_row (bank_row),
    .bank_wd  (bank_wd),
    .serve    (serve)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    bcs_bank #(.DW(DW), .RW(RW)) u_bank (
      .clk (clk),
      .en  (bank_en[b]),
      .we  (write_q),
      .row (bank_row[b*RW +: RW]),
      .wd  (bank_wd[b*DW +: DW]),
      .q   (bank_q[b*DW +: DW])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bank[l*BW +: BW] = addr_q[l*AW +: BW];
  end

  bcs_gather #(.LANES(LANES), .BANKS(BANKS), .DW(DW)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .cap       (cap_d),
    .serve     (serve_d),
    .lane_bank (lane_bank),
    .bank_q    (bank_q),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= '0;
      serve_d <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      cap_d   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      pass_q  <= '0;
    end else begin
      done_q <= 1'b0;
      cap_d  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            pend    <= req_lane_en;
            cnt_q   <= '0;
            state   <= ST_PASS;
          end
        end
        ST_PASS: begin
          pend    <= pend_left;
          serve_d <= serve;
          cap_d   <= !write_q;
          cnt_q   <= cnt_q + 1'b1;
          if (pend_left == '0) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          done_q <= 1'b1;
          pass_q <= cnt_q;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign pass_cnt  = pass_q;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int LANES = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [CW-1:0] pass_cnt
);
  logic [7:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)                         cyc <= '0;
    else if (req_valid && req_ready) cyc <= 8'd1;
    else if (done)                   cyc <= '0;
    else if (cyc != 0)               cyc <= cyc + 8'd1;
  end

  // R6: ready drops once a request is taken
  a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: ready is high in the done cycle
  a_r6_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  // R6: latency matches the reported pass count
  a_r6_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == 8'(pass_cnt) + 8'd2));

  // R6: no completion without an accepted request
  a_r6_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    (cyc == 8'd0) |-> !done);

  // R7: pass count range
  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    done |-> ((pass_cnt >= CW'(1)) && (pass_cnt <= CW'(LANES))));
endmodule

bind bank_conflict_serializer bcs_checker #(.LANES(LANES), .CW(CW)) u_bcs_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .pass_cnt  (pass_cnt)
);

// File: tb/sim_bank_conflict_serializer.sv
`timescale 1ns/1ps
module sim_bank_conflict_serializer;
  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int WORDS = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [LANES-1:0]     req_lane_en = '0;
  logic                 req_write = 1'b0;
  logic [LANES*AW-1:0]  req_addr = '0;
  logic [LANES*DW-1:0]  req_wdata = '0;
  logic                 done;
  logic [5:0]           pass_cnt;
  logic [LANES*DW-1:0]  rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [LANES-1:0] en_b;
  logic [AW-1:0]    a_b [LANES];
  logic [DW-1:0]    d_b [LANES];
  logic             we_b;
  int               exp_pass;
  logic [DW-1:0]    model [WORDS];

  bank_conflict_serializer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_en(req_lane_en), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .pass_cnt(pass_cnt), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return 32'h5A5A0000 ^ (a * 32'h9E3779B1) ^ s;
  endfunction

  function automatic int calc_pass();
    int mx = 0;
    for (int b = 0; b < 32; b++) begin
      int c = 0;
      for (int l = 0; l < LANES; l++) begin
        if (en_b[l] && (a_b[l][4:0] == 5'(b))) begin
          bit dup = 0;
          for (int j = 0; j < l; j++)
            if (en_b[j] && a_b[j] == a_b[l]) dup = 1;
          if (!dup) c++;
        end
      end
      if (c > mx) mx = c;
    end
    return (mx == 0) ? 1 : mx;
  endfunction

  task automatic start();
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW]  = a_b[l];
      req_wdata[l*DW +: DW] = d_b[l];
    end
    req_lane_en = en_b;
    req_write   = we_b;
    req_valid   = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_pass = calc_pass();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R6", "ready low after accept", req_ready, 0);
  endtask

  task automatic finish(input string tag);
    int k = 0;
    while (!done && k < 200) begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    chk(done == 1'b1, "R6", "done seen", done, 1);
    chk(k == exp_pass + 1, "R6", "done latency", k, exp_pass + 1);
    chk(req_ready == 1'b1, "R6", "ready in done cycle", req_ready, 1);
    chk(pass_cnt == 6'(exp_pass), tag, "pass count", pass_cnt, exp_pass);
    if (we_b) begin
      chk(rd_data == '0, "R8", "write request rd_data", rd_data[63:0], 0);
      for (int l = LANES - 1; l >= 0; l--)
        if (en_b[l]) model[a_b[l]] = d_b[l];
    end else begin
      for (int l = 0; l < LANES; l++) begin
        logic [DW-1:0] e = en_b[l] ? model[a_b[l]] : '0;
        chk(rd_data[l*DW +: DW] == e, en_b[l] ? tag : "R8",
            $sformatf("lane %0d data", l), rd_data[l*DW +: DW], e);
      end
    end
  endtask

  task automatic run(input string tag);
    start();
    finish(tag);
  endtask

  // R9
  task automatic t_reset();
    chk(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(pass_cnt == 6'd0, "R9", "reset pass_cnt", pass_cnt, 0);
    chk(rd_data == '0, "R9", "reset rd_data", rd_data[63:0], 0);
  endtask

  // R1, R2: fill every word with distinct-bank writes
  task automatic t_fill();
    for (int r = 0; r < 32; r++) begin
      en_b = '1; we_b = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        a_b[l] = AW'(r * 32 + l);
        d_b[l] = pat(r * 32 + l, 1);
      end
      run("R2");
    end
  endtask

  // R1: permuted distinct-bank read
  task automatic t_scatter_read();
    en_b = '1; we_b = 1'b0;
    for (int l = 0; l < LANES; l++)
      a_b[l] = AW'(((l * 7) % 32) + 32 * ((l * 3) % 32));
    run("R1");
  endtask

  // R3: eight lanes conflict on bank 5
  task automatic t_bank_conflict();
    en_b = '1; we_b = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      a_b[l] = (l < 8) ? AW'(5 + 32 * (l * 4 + 1)) : AW'(l + 32 * 7);
      d_b[l] = pat(l, 3);
    end
    run("R3");
    we_b = 1'b0;
    run("R3");
  endtask

  // R7, R3: worst case, all lanes in bank 9
  task automatic t_full_conflict();
    en_b = '1; we_b = 1'b0;
    for (int l = 0; l < LANES; l++) a_b[l] = AW'(9 + 32 * l);
    run("R7");
  endtask

  // R4: broadcast and a mix of merge and conflict
  task automatic t_broadcast();
    en_b = '1; we_b = 1'b0;
    for (int l = 0; l < LANES; l++) a_b[l] = AW'(77);
    run("R4");
    for (int l = 0; l < LANES; l++)
      a_b[l] = (l % 2 == 0) ? AW'(3 + 64) : AW'(3 + 32 * (10 + (l >> 1) % 4));
    run("R4");
  endtask

  // R5: duplicate writes to one word, lowest lane wins
  task automatic t_dup_write();
    en_b = '0; we_b = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      a_b[l] = AW'(l + 32 * 21);
      d_b[l] = pat(l, 5);
    end
    en_b[3:0] = 4'hF;
    en_b[4] = 1'b1;  a_b[4]  = AW'(200);
    en_b[9] = 1'b1;  a_b[9]  = AW'(200);
    en_b[20] = 1'b1; a_b[20] = AW'(200);
    run("R5");
    en_b = 32'h1; we_b = 1'b0; a_b[0] = AW'(200);
    start();
    finish("R5");
    chk(rd_data[DW-1:0] == pat(4, 5), "R5", "lowest writer kept",
        rd_data[DW-1:0], pat(4, 5));
  endtask

  // R10, R8: disabled lanes and hold of read data
  task automatic t_masked();
    logic [LANES*DW-1:0] snap;
    en_b = 32'h0000_0011; we_b = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      a_b[l] = AW'(32 * l);
      d_b[l] = 32'hDEAD_0000 + DW'(l);
    end
    run("R10");
    en_b = '1; we_b = 1'b0;
    run("R10");
    en_b = 32'h8421_0F0F;
    run("R8");
    snap = rd_data;
    repeat (3) @(negedge clk);
    chk(rd_data == snap, "R8", "rd_data held", rd_data[63:0], snap[63:0]);
  endtask

  // R7: empty request
  task automatic t_empty();
    en_b = '0; we_b = 1'b0;
    for (int l = 0; l < LANES; l++) a_b[l] = AW'(9 + 32 * l);
    run("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_scatter_read();
    t_bank_conflict();
    t_full_conflict();
    t_broadcast();
    t_dup_write();
    t_masked();
    t_empty();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule